// File: doc/BRIEF.md
# Decimal Tick Counter with Key-Hold Display Override

This block drives a 4-bit LED field. Normally the field shows a single decimal digit that advances once per second and wraps from 9 back to 0. A one-cycle key-valid strobe carries a 4-bit key number. When the strobe arrives, that number is captured and shown in place of the digit for five one-second ticks. After that the field goes back to the digit.

The digit keeps advancing during the override. When the override ends, the field shows the current count, not the value it had when the key was pressed. A second key during the override replaces the shown number and starts the five-tick hold again. The number of clock cycles per tick is a parameter, so a test can use a short tick while the default gives one second at 125 MHz.

Top module: `key_count_display`

## Requirements
- R1: After reset the count is 0, no key hold is active, and leds_o shows 0.
- R2: The count advances by exactly one on every tick. A tick occurs once every TICK_CYCLES clock cycles: the first tick is at the TICK_CYCLES-th rising edge after reset is released.
- R3: The count wraps from 9 to 0 on the tick that follows 9.
- R4: When key_valid_i is high at a clock edge, leds_o shows key_code_i from that edge onward (bit 0 of leds_o is bit 0 of the code).
- R5: The key number stays on leds_o until the fifth tick after the press. A tick on the same edge as the press is not counted. leds_o returns to the count on that fifth tick edge.
- R6: The count keeps advancing during a key hold, and when the hold ends leds_o shows the count as it stands at that time.
- R7: A key press during an active hold replaces the shown key number and restarts the five-tick hold from the new press.
- R8: While key_valid_i is low, key_code_i has no effect on leds_o.
- R9: Asserting rst_ni low at any time, including during a hold, immediately forces leds_o to 0 and cancels the hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_valid_i | input | 1 | One-cycle strobe: key_code_i holds a new key number |
| key_code_i | input | 4 | Key number to display |
| leds_o | output | 4 | Displayed value: the count or the held key number |

## Verification
The hardest case to reach is a press on the same clock edge as a tick. Here the hold reload must take priority over the decrement, and the tick must not count toward the five. The stimulus reaches it by stepping the clock one edge at a time from reset release. The bench keeps its own edge count, so it can land a press exactly on a multiple of the tick period. It also lands a retrigger inside an active hold, and an asynchronous reset in the middle of a hold.

// File: rtl/key_count_display_pkg.sv
package key_count_display_pkg;
  parameter int unsigned DISP_W = 4;
  typedef logic [DISP_W-1:0] disp_t;
endpackage

// File: rtl/sec_tick_gen.sv
module sec_tick_gen #(
  parameter int unsigned TICK_CYCLES = 125_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_CYCLES < 2) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(TICK_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      assign tick_o = (cnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/dec_digit_counter.sv
module dec_digit_counter
  import key_count_display_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  output disp_t count_o
);
  localparam disp_t TOP = disp_t'(MODULUS - 1);
  disp_t count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (tick_i) count_q <= (count_q == TOP) ? '0 : count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/key_hold_ctrl.sv
module key_hold_ctrl
  import key_count_display_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  key_valid_i,
  input  disp_t key_code_i,
  output logic  active_o,
  output disp_t key_o
);
  localparam int unsigned HW = $clog2(HOLD_TICKS + 1);
  localparam logic [HW-1:0] RELOAD = HW'(HOLD_TICKS);

  logic [HW-1:0] left_q;
  disp_t         key_q;

  // press wins over a same-edge tick: that tick is not counted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      key_q  <= '0;
    end else if (key_valid_i) begin
      left_q <= RELOAD;
      key_q  <= key_code_i;
    end else if (tick_i && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign active_o = (left_q != '0);
  assign key_o    = key_q;
endmodule

// File: rtl/key_count_display.sv
module key_count_display
  import key_count_display_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 125_000_000,
  parameter int unsigned HOLD_TICKS  = 5,
  parameter int unsigned MODULUS     = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_valid_i,
  input  logic [DISP_W-1:0] key_code_i,
  output logic [DISP_W-1:0] leds_o
);
  logic  tick;
  logic  hold_active;
  disp_t count_q;
  disp_t key_q;

  sec_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  dec_digit_counter #(.MODULUS(MODULUS)) u_count (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .count_o(count_q)
  );

  key_hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .key_valid_i(key_valid_i),
    .key_code_i (key_code_i),
    .active_o   (hold_active),
    .key_o      (key_q)
  );

  assign leds_o = hold_active ? key_q : count_q;
endmodule

// File: rtl/key_count_display_chk.sv
module key_count_display_chk
  import key_count_display_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input logic  clk_i,
  input logic  rst_ni,
  input logic  key_valid_i,
  input disp_t key_code_i,
  input disp_t leds_o,
  input logic  tick_i,
  input disp_t count_i,
  input logic  hold_i
);
  localparam disp_t TOP = disp_t'(MODULUS - 1);

  // R2
  count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_i));

  // R2
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_i != TOP) |=> count_i == $past(count_i) + 1'b1);

  // R3
  count_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && count_i == TOP) |=> count_i == '0);

  // R4
  key_shown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> (hold_i && leds_o == $past(key_code_i)));

  // R6
  count_shown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |-> leds_o == count_i);

  // R8
  code_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_valid_i && hold_i) |=> (!hold_i || $stable(leds_o)));

  // R5
  hold_ends_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_i) |-> $past(tick_i));
endmodule

bind key_count_display key_count_display_chk #(.MODULUS(MODULUS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .key_valid_i(key_valid_i),
  .key_code_i (key_code_i),
  .leds_o     (leds_o),
  .tick_i     (tick),
  .count_i    (count_q),
  .hold_i     (hold_active)
);

// File: tb/key_count_display_test.sv
module key_count_display_test;
  localparam int N    = 8;
  localparam int HOLD = 5;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       key_valid_i;
  logic [3:0] key_code_i;
  logic [3:0] leds_o;

  int errors = 0;
  int checks = 0;
  int e = 0;
  int end_edge = 0;
  bit have_press = 0;
  bit retrig = 0;
  logic [3:0] last_code = '0;

  // {key_valid, key_code, idle steps}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 4'h5, 8'd20},
    {1'b1, 4'hA, 8'd10},
    {1'b0, 4'h3, 8'd5},
    {1'b1, 4'h7, 8'd50},
    {1'b1, 4'hF, 8'd90},
    {1'b0, 4'hC, 8'd100}
  };

  always #4 clk = ~clk;

  key_count_display #(.TICK_CYCLES(N), .HOLD_TICKS(HOLD)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .key_valid_i(key_valid_i),
    .key_code_i (key_code_i),
    .leds_o     (leds_o)
  );

  task automatic check(input string tag, input logic [3:0] exp);
    checks++;
    if (leds_o !== exp) begin
      errors++;
      $display("FAIL %s edge=%0d leds=%h expected=%h", tag, e, leds_o, exp);
    end
  endtask

  // one clock edge; entered and left at a falling edge
  task automatic step(input logic kv, input logic [3:0] code);
    logic [3:0] exp;
    string tag;
    key_valid_i = kv;
    key_code_i  = code;
    @(posedge clk);
    e++;
    if (kv) begin
      retrig     = have_press && (e - 1) < end_edge;
      have_press = 1;
      last_code  = code;
      end_edge   = ((e / N) + 1) * N + (HOLD - 1) * N;
    end
    @(negedge clk);
    key_valid_i = 1'b0;
    if (have_press && e < end_edge) begin
      exp = last_code;
      if (kv) tag = retrig ? "R7" : "R4";
      else    tag = retrig ? "R7 R8" : "R5 R8";
    end else begin
      exp = 4'((e / N) % 10);
      if (have_press && e < end_edge + N) tag = "R5 R6";
      else if (exp == 0 && e >= 10 * N)   tag = "R3";
      else                                tag = "R2";
    end
    check(tag, exp);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    key_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    e = 0;
    have_press = 0;
    retrig = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    key_valid_i = 1'b0;
    key_code_i = 4'h9;
    repeat (3) @(negedge clk);
    check("R1", 4'h0);
    do_reset();
    check("R1", 4'h0);

    foreach (VEC[i]) begin
      step(VEC[i][12], VEC[i][11:8]);
      for (int k = 0; k < int'(VEC[i][7:0]); k++) step(1'b0, ~VEC[i][11:8]);
    end

    // press on the same edge as a tick: that tick must not count (R5)
    while (((e + 1) % N) != 0) step(1'b0, 4'h0);
    step(1'b1, 4'h6);
    for (int k = 0; k < HOLD * N + 3; k++) step(1'b0, 4'h1);

    // press one edge before a tick
    while (((e + 2) % N) != 0) step(1'b0, 4'h0);
    step(1'b1, 4'h2);
    for (int k = 0; k < 2 * N; k++) step(1'b0, 4'hE);
    step(1'b1, 4'hB); // R7 retrigger
    for (int k = 0; k < HOLD * N + 3; k++) step(1'b0, 4'h4);

    // asynchronous reset during a hold (R9)
    step(1'b1, 4'hD);
    for (int k = 0; k < 3; k++) step(1'b0, 4'h0);
    rst_ni = 1'b0;
    #1;
    check("R9", 4'h0);
    do_reset();
    check("R1", 4'h0);
    for (int k = 0; k < 3 * N; k++) step(1'b0, 4'h8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule